// File: doc/BRIEF.md
# Static LCD Reading Latch and Backplane Driver

This block sits between the digit counters of a measurement core and a static three-and-a-half-digit seven-segment liquid-crystal panel. It takes three BCD digits and a one-bit thousands digit from the core. It also takes a sign flag, a load strobe and a hold level. On every load strobe that arrives while hold is low, it captures the reading into display latches. While hold is high the strobes are ignored. The counters upstream keep converting, but the panel keeps showing the frozen value until hold drops and the next strobe arrives.

A two-stage clock divider makes a square-wave backplane with a 50% duty cycle. With the default parameters the backplane period is 800 input clocks. Every segment output is either a copy of the backplane or its complement. A dark segment is driven in phase with the backplane. A lit segment is driven in antiphase. This keeps the average voltage across each liquid-crystal cell at zero.

External decimal-point select levels are combined with the backplane in the same way. The backplane, the segment outputs and the decimal-point outputs all come from registers that update on the same clock edge, so they never drift apart. Tie hold low to update the display on every load.

Top module: `lcd_backplane_drv`

## Requirements
- R1: Out of reset the backplane is low. It then toggles every PRE_DIV*MAIN_DIV/2 clock cycles, giving a 50% duty cycle. Counting the first clock edge with reset low as edge 0, the backplane after edge n equals ((n+1)/(PRE_DIV*MAIN_DIV/2)) mod 2.
- R2: Each segment output equals its lit state XOR the backplane. A dark segment is at the same level as the backplane, and a lit segment is at the opposite level.
- R3: With hold low, the clock edge that samples the load strobe high captures the digits, the thousands bit and the sign. The segment outputs show the new reading from the following edge.
- R4: While hold is high, load strobes leave the digits, the thousands bit and the sign unchanged on the outputs.
- R5: After hold returns low, the display stays unchanged until a load strobe arrives. That strobe updates it as in R3.
- R6: The thousands output drives segments b and c together. It is in antiphase when the latched thousands bit is 1 and in phase when the bit is 0.
- R7: The minus output is in antiphase when the latched sign flag is 1 (negative) and in phase when it is 0.
- R8: A full digit decodes BCD 0 to 9 to the standard patterns, with segment a at bit 0 through segment g at bit 6. The patterns in hex are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F.
- R9: Codes 10 to 15 on a full digit leave all seven segments dark.
- R10: Each decimal-point output equals its select input XOR the backplane, registered on the same edge as the backplane.
- R11: While reset is high, the backplane and every segment and decimal-point output are low. After reset the latches hold zeros with the sign off, so the display reads "000" with the thousands and minus segments dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| onesIn | input | 4 | Ones digit, BCD |
| tensIn | input | 4 | Tens digit, BCD |
| hundIn | input | 4 | Hundreds digit, BCD |
| thouIn | input | 1 | Thousands half digit (1 lights b and c) |
| negIn | input | 1 | Sign flag, 1 for a negative reading |
| loadIn | input | 1 | One-cycle strobe to capture a reading |
| holdIn | input | 1 | 1 blocks latch updates |
| dpSelIn | input | DP_N | Decimal-point select levels |
| backplane | output | 1 | Backplane square wave |
| segOnes | output | 7 | Ones segments, a at bit 0 |
| segTens | output | 7 | Tens segments, a at bit 0 |
| segHund | output | 7 | Hundreds segments, a at bit 0 |
| segThou | output | 1 | Thousands b-and-c segment drive |
| segMinus | output | 1 | Minus sign segment drive |
| dpOut | output | DP_N | Decimal-point drives |

## Verification
The bench builds the block with PRE_DIV=2, MAIN_DIV=6 and DP_N=2. This gives a backplane half period of six clocks, so several full backplane periods fit between loads. The bench can check the exact toggle edges of R1 and see a lit digit at both backplane levels within a few dozen cycles. The small prescale still exercises both divider stages and their carry from the first stage into the second. A two-bit decimal-point bus is enough to show one selected point and one unselected point together.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int SEG_W = 7;
  localparam int BCD_W = 4;
  localparam int FULL_DIGITS = 3;

  typedef struct packed {
    logic phaseFlip;
    logic latchEn;
  } drvStrobe_t;

  typedef struct packed {
    logic [FULL_DIGITS-1:0][BCD_W-1:0] digits;
    logic thou;
    logic neg;
  } reading_t;

  function automatic logic [SEG_W-1:0] bcdToSeg(input logic [BCD_W-1:0] code);
    logic [SEG_W-1:0] pat;
    case (code)
      4'd0: pat = 7'h3F;
      4'd1: pat = 7'h06;
      4'd2: pat = 7'h5B;
      4'd3: pat = 7'h4F;
      4'd4: pat = 7'h66;
      4'd5: pat = 7'h6D;
      4'd6: pat = 7'h7D;
      4'd7: pat = 7'h07;
      4'd8: pat = 7'h7F;
      4'd9: pat = 7'h6F;
      default: pat = '0;
    endcase
    return pat;
  endfunction
endpackage

// File: rtl/lcd_drv_ctrl.sv
module lcd_drv_ctrl
  import lcd_drv_pkg::*;
#(
  parameter int PRE_DIV  = 4,
  parameter int MAIN_DIV = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       loadIn,
  input  logic       holdIn,
  output drvStrobe_t strb
);
  localparam int HALF_TICKS = MAIN_DIV / 2;
  localparam int PRE_W  = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int MAIN_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(PRE_DIV - 1);
  localparam logic [MAIN_W-1:0] MAIN_LAST = MAIN_W'(HALF_TICKS - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [MAIN_W-1:0] mainCnt;
  logic              preTick;

  assign preTick = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt  <= '0;
      mainCnt <= '0;
    end else begin
      preCnt <= preTick ? '0 : preCnt + 1'b1;
      if (preTick) begin
        mainCnt <= (mainCnt == MAIN_LAST) ? '0 : mainCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.phaseFlip = preTick && (mainCnt == MAIN_LAST);
    strb.latchEn   = loadIn && !holdIn;
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
    preCnt <= PRE_LAST); // R1
  AST_MAIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    mainCnt <= MAIN_LAST); // R1
endmodule

// File: rtl/lcd_drv_datapath.sv
module lcd_drv_datapath
  import lcd_drv_pkg::*;
#(
  parameter int DP_N = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  drvStrobe_t                          strb,
  input  reading_t                            rdIn,
  input  logic [DP_N-1:0]                     dpSelIn,
  output logic                                bpOut,
  output logic [FULL_DIGITS-1:0][SEG_W-1:0]   segOut,
  output logic                                thouOut,
  output logic                                minusOut,
  output logic [DP_N-1:0]                     dpOut
);
  reading_t latchQ;
  logic     bpQ;
  logic     bpNext;

  assign bpNext = bpQ ^ strb.phaseFlip;

  always_ff @(posedge clk) begin
    if (rst) begin
      latchQ <= '0;
    end else if (strb.latchEn) begin
      latchQ <= rdIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bpQ      <= 1'b0;
      thouOut  <= 1'b0;
      minusOut <= 1'b0;
      dpOut    <= '0;
    end else begin
      bpQ      <= bpNext;
      thouOut  <= latchQ.thou ^ bpNext;
      minusOut <= latchQ.neg ^ bpNext;
      dpOut    <= dpSelIn ^ {DP_N{bpNext}};
    end
  end

  for (genvar g = 0; g < FULL_DIGITS; g++) begin : gDigit
    always_ff @(posedge clk) begin
      if (rst) begin
        segOut[g] <= '0;
      end else begin
        segOut[g] <= bcdToSeg(latchQ.digits[g]) ^ {SEG_W{bpNext}};
      end
    end
  end

  assign bpOut = bpQ;

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
    !strb.latchEn |=> $stable(latchQ)); // R4
  AST_MINUS_PHASE: assert property (@(posedge clk) disable iff (rst)
    (minusOut ^ bpQ) == $past(latchQ.neg)); // R7
  AST_THOU_PHASE: assert property (@(posedge clk) disable iff (rst)
    (thouOut ^ bpQ) == $past(latchQ.thou)); // R6
endmodule

// File: rtl/lcd_backplane_drv.sv
module lcd_backplane_drv
  import lcd_drv_pkg::*;
#(
  parameter int PRE_DIV  = 4,
  parameter int MAIN_DIV = 200,
  parameter int DP_N     = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      onesIn,
  input  logic [3:0]      tensIn,
  input  logic [3:0]      hundIn,
  input  logic            thouIn,
  input  logic            negIn,
  input  logic            loadIn,
  input  logic            holdIn,
  input  logic [DP_N-1:0] dpSelIn,
  output logic            backplane,
  output logic [6:0]      segOnes,
  output logic [6:0]      segTens,
  output logic [6:0]      segHund,
  output logic            segThou,
  output logic            segMinus,
  output logic [DP_N-1:0] dpOut
);
  drvStrobe_t                        strb;
  reading_t                          rd;
  logic [FULL_DIGITS-1:0][SEG_W-1:0] segBus;

  always_comb begin
    rd.digits[0] = onesIn;
    rd.digits[1] = tensIn;
    rd.digits[2] = hundIn;
    rd.thou      = thouIn;
    rd.neg       = negIn;
  end

  lcd_drv_ctrl #(.PRE_DIV(PRE_DIV), .MAIN_DIV(MAIN_DIV)) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .loadIn (loadIn),
    .holdIn (holdIn),
    .strb   (strb)
  );

  lcd_drv_datapath #(.DP_N(DP_N)) uPath (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .rdIn     (rd),
    .dpSelIn  (dpSelIn),
    .bpOut    (backplane),
    .segOut   (segBus),
    .thouOut  (segThou),
    .minusOut (segMinus),
    .dpOut    (dpOut)
  );

  assign segOnes = segBus[0];
  assign segTens = segBus[1];
  assign segHund = segBus[2];

  AST_BP_FLIP_ONLY: assert property (@(posedge clk) disable iff (rst)
    (backplane != $past(backplane)) |-> $past(strb.phaseFlip)); // R1
  AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    holdIn |-> !strb.phaseFlip || !strb.latchEn); // R4
endmodule

// File: tb/tb_lcd_backplane_drv.sv
module tb_lcd_backplane_drv;
  localparam int PRE  = 2;
  localparam int MAIN = 6;
  localparam int DPN  = 2;
  localparam int HALF = PRE * MAIN / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] onesIn = '0, tensIn = '0, hundIn = '0;
  logic thouIn = 1'b0, negIn = 1'b0, loadIn = 1'b0, holdIn = 1'b0;
  logic [DPN-1:0] dpSelIn = 2'b01;
  logic backplane, segThou, segMinus;
  logic [6:0] segOnes, segTens, segHund;
  logic [DPN-1:0] dpOut;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lcd_backplane_drv #(.PRE_DIV(PRE), .MAIN_DIV(MAIN), .DP_N(DPN)) dut (
    .clk(clk), .rst(rst), .onesIn(onesIn), .tensIn(tensIn), .hundIn(hundIn),
    .thouIn(thouIn), .negIn(negIn), .loadIn(loadIn), .holdIn(holdIn),
    .dpSelIn(dpSelIn), .backplane(backplane), .segOnes(segOnes),
    .segTens(segTens), .segHund(segHund), .segThou(segThou),
    .segMinus(segMinus), .dpOut(dpOut)
  );

  // {ones, tens, hund, thou, neg, expOnes, expTens, expHund}
  localparam logic [34:0] VEC [0:7] = '{
    {4'd1,  4'd2,  4'd3,  1'b1, 1'b0, 7'h06, 7'h5B, 7'h4F},
    {4'd4,  4'd5,  4'd6,  1'b0, 1'b1, 7'h66, 7'h6D, 7'h7D},
    {4'd7,  4'd8,  4'd9,  1'b1, 1'b1, 7'h07, 7'h7F, 7'h6F},
    {4'd0,  4'd10, 4'd15, 1'b0, 1'b0, 7'h3F, 7'h00, 7'h00},
    {4'd12, 4'd0,  4'd11, 1'b1, 1'b0, 7'h00, 7'h3F, 7'h00},
    {4'd9,  4'd0,  4'd1,  1'b0, 1'b1, 7'h6F, 7'h3F, 7'h06},
    {4'd13, 4'd14, 4'd8,  1'b1, 1'b1, 7'h00, 7'h00, 7'h7F},
    {4'd2,  4'd3,  4'd5,  1'b0, 1'b0, 7'h5B, 7'h4F, 7'h6D}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doLoad(input logic [3:0] o, input logic [3:0] t, input logic [3:0] h,
                        input logic th, input logic ng);
    @(negedge clk);
    onesIn = o; tensIn = t; hundIn = h; thouIn = th; negIn = ng; loadIn = 1'b1;
    @(negedge clk);
    loadIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkShown(input string tag, input logic [6:0] eo, input logic [6:0] et,
                            input logic [6:0] eh, input logic th, input logic ng);
    check({tag, " ones"},  {1'b0, segOnes ^ {7{backplane}}}, {1'b0, eo});
    check({tag, " tens"},  {1'b0, segTens ^ {7{backplane}}}, {1'b0, et});
    check({tag, " hund"},  {1'b0, segHund ^ {7{backplane}}}, {1'b0, eh});
    check({tag, " thou R6"},  {7'b0, segThou ^ backplane},  {7'b0, th});
    check({tag, " minus R7"}, {7'b0, segMinus ^ backplane}, {7'b0, ng});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: outputs low during reset
    check("R11 bp in reset", {7'b0, backplane}, 8'h00);
    check("R11 segs in reset", {1'b0, segOnes | segTens | segHund}, 8'h00);
    check("R11 thou/minus/dp in reset", {4'b0, segThou, segMinus, dpOut}, 8'h00);
    rst = 1'b0;
    // R1 and R10: backplane timing and decimal points from the first edge
    for (int n = 0; n < 4 * HALF; n++) begin
      @(negedge clk);
      check("R1 backplane", {7'b0, backplane}, 8'(((n + 1) / HALF) % 2));
      if (n % 5 == 0) check("R10 dp", {6'b0, dpOut}, {6'b0, dpSelIn ^ {DPN{backplane}}});
    end
    // R11: reset-cleared latches show 000
    checkShown("R11 after reset", 7'h3F, 7'h3F, 7'h3F, 1'b0, 1'b0);
    // R3 R8 R9: table walk
    for (int i = 0; i < 8; i++) begin
      logic [34:0] v;
      v = VEC[i];
      doLoad(v[34:31], v[30:27], v[26:23], v[22], v[21]);
      checkShown("R3 R8 R9 table", v[20:14], v[13:7], v[6:0], v[22], v[21]);
    end
    // R3: update lands exactly on the edge after capture
    @(negedge clk);
    onesIn = 4'd8; loadIn = 1'b1;
    @(negedge clk);
    loadIn = 1'b0;
    check("R3 not before next edge", {1'b0, segOnes ^ {7{backplane}}}, 8'h5B);
    @(negedge clk);
    check("R3 shown", {1'b0, segOnes ^ {7{backplane}}}, 8'h7F);
    // R4: hold freezes
    holdIn = 1'b1;
    doLoad(4'd9, 4'd9, 4'd9, 1'b1, 1'b1);
    repeat (HALF) @(negedge clk);
    checkShown("R4 held", 7'h7F, 7'h4F, 7'h6D, 1'b0, 1'b0);
    // R5: release without load keeps display
    holdIn = 1'b0;
    repeat (3) @(negedge clk);
    checkShown("R5 released no load", 7'h7F, 7'h4F, 7'h6D, 1'b0, 1'b0);
    doLoad(4'd9, 4'd9, 4'd9, 1'b1, 1'b1);
    checkShown("R5 load after release", 7'h6F, 7'h6F, 7'h6F, 1'b1, 1'b1);
    // R2: raw levels at both backplane phases
    for (int k = 0; k < 2 * HALF && backplane !== 1'b0; k++) @(negedge clk);
    check("R2 lit antiphase bp=0", {1'b0, segOnes}, 8'h6F);
    check("R2 off in phase bp=0", {1'b0, segOnes & 7'h10}, 8'h00);
    for (int k = 0; k < 2 * HALF && backplane !== 1'b1; k++) @(negedge clk);
    check("R2 lit antiphase bp=1", {1'b0, segOnes}, 8'h10);
    dpSelIn = 2'b10;
    @(negedge clk);
    check("R10 dp change", {6'b0, dpOut}, {6'b0, 2'b10 ^ {DPN{backplane}}});
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule